// File: doc/BRIEF.md
# Privilege Mode Controller

This block keeps track of whether the processor core runs its privileged (supervisor) context or its unprivileged (user) context, and drives the select line that picks one of two register banks. It has no vector table and saves no state. When an interrupt, a trap or a fault occurs in user mode, the block switches back to the supervisor bank. Supervisor code then reads a sticky cause code to find out why control came back.

User mode is entered when the supervisor sets the global interrupt enable bit, or when it issues a wait. Either request is refused while an interrupt is pending. A wait or a halt issued from user mode puts the core to sleep until the next interrupt. A halt in supervisor mode, or a breakpoint in either mode, stops the core until reset.

A lock request opens an atomic window. The window lasts for a fixed number of retired instructions. During the window the block holds the bus cycle open and defers interrupt recognition. An interrupt that stays pending is acted on once the window closes.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset the block is in supervisor mode (`user_mode`=0, `bank_sel`=SUP_BANK=0). `sleeping`, `halted` and `bus_hold` are all 0, and `exc_cause` is 0 (none).
- R2: In supervisor mode, a `gie_set` pulse with no effective interrupt pending switches to user mode on the next clock edge (`bank_sel`=USR_BANK=1) and clears `exc_cause` to 0.
- R3: In supervisor mode, a `gie_set` or `wait_req` pulse has no effect while an effective interrupt is pending: the mode stays supervisor and `exc_cause` is unchanged.
- R4: In user mode, an effective pending interrupt switches to supervisor mode and sets `exc_cause`=1. This also ends sleep.
- R5: In user mode and not asleep, a `gie_clr` pulse switches to supervisor mode and sets `exc_cause`=2 (trap).
- R6: In user mode and not asleep, a fault switches to supervisor mode and records its cause. The codes are bus error=3, illegal instruction=4 and divide by zero=5. When several faults arrive in one cycle, priority runs bus error, then illegal instruction, then divide by zero. A fault outranks `gie_clr`.
- R7: A `sim_op` pulse in user mode is treated as an illegal instruction (`exc_cause`=4) when SIM_OP_TRAPS=1, which is the default.
- R8: A `wait_req` in supervisor mode, with no interrupt pending, enters user mode asleep. A `wait_req` or `halt_req` in user mode sets `sleeping`. While asleep, every input except an interrupt, a break and the lock inputs is ignored. `sleeping` implies `user_mode`.
- R9: A `halt_req` in supervisor mode sets `halted`. Once set, `halted` is held, and mode, sleep and cause stay frozen until reset.
- R10: A `brk_req` in either mode sets `halted` on the next edge and leaves the mode and the cause unchanged.
- R11: A `lock_req` asserts `bus_hold` from the next edge until LOCK_INSNS=3 `insn_retire` pulses have been seen. While `bus_hold` is 1, `irq_pend` is not acted on. The interrupt takes effect on the first edge after `bus_hold` falls, if it is still pending.
- R12: `exc_cause` is sticky in supervisor mode: a fault pulse or `gie_clr` in supervisor mode changes neither the mode nor the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | 1 | Level: an interrupt is pending |
| gie_set | input | 1 | Pulse: condition-code write sets the interrupt enable bit |
| gie_clr | input | 1 | Pulse: condition-code write clears the interrupt enable bit |
| bus_err | input | 1 | Pulse: bus error |
| ill_insn | input | 1 | Pulse: illegal instruction |
| div_zero | input | 1 | Pulse: divide by zero |
| wait_req | input | 1 | Pulse: wait instruction |
| halt_req | input | 1 | Pulse: halt instruction |
| brk_req | input | 1 | Pulse: breakpoint reached |
| lock_req | input | 1 | Pulse: lock instruction |
| sim_op | input | 1 | Pulse: simulation-only opcode decoded |
| insn_retire | input | 1 | Pulse: one instruction retired |
| user_mode | output | 1 | 1 in user mode |
| bank_sel | output | BANK_W | Active register bank index |
| sleeping | output | 1 | Core asleep awaiting interrupt |
| halted | output | 1 | Core stopped until reset |
| exc_cause | output | 3 | Sticky cause of the last return to supervisor |
| bus_hold | output | 1 | Hold the bus cycle open (atomic window) |

## Verification
The embedded assertions check on every cycle that a halt never clears, that sleep only occurs in user mode, that each user-mode entry leaves a zero cause, that a pending interrupt blocks the enable write, and that no interrupt cause is recorded while the lock window is open. Only the bench scenarios can show the exact cause codes and their priority, the treatment of the simulation-only opcode, a fault being ignored while asleep, and the interrupt taking effect on the first edge after the window closes. The bench's reference model compares every output on every cycle across all these sequences.

// File: rtl/priv_mode_pkg.sv
package priv_mode_pkg;

   typedef enum logic [2:0] {
      CAUSE_NONE   = 3'd0,
      CAUSE_IRQ    = 3'd1,
      CAUSE_TRAP   = 3'd2,
      CAUSE_BUSERR = 3'd3,
      CAUSE_ILLOP  = 3'd4,
      CAUSE_DIVZ   = 3'd5
   } cause_e;

   localparam int CAUSE_W = 3;

endpackage

// File: rtl/lock_window.sv
module lock_window #(
   parameter int LOCK_INSNS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_req,
   input  logic insn_retire,
   output logic lock_act
);
   localparam int CNT_W = $clog2(LOCK_INSNS + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_INSNS);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (LOCK_INSNS < 1) begin : g_bad_len
         $error("lock_window: LOCK_INSNS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (lock_req) begin
         cnt_q <= CNT_LOAD;
      end else if (insn_retire && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign lock_act = (cnt_q != '0);

   AST_LOCK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      lock_req |=> lock_act); // R11

   AST_LOCK_NO_RETIRE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_act && !insn_retire) |=> lock_act); // R11

endmodule

// File: rtl/fault_decode.sv
module fault_decode
   import priv_mode_pkg::*;
#(
   parameter bit SIM_OP_TRAPS = 1'b1
) (
   input  logic   bus_err,
   input  logic   ill_insn,
   input  logic   div_zero,
   input  logic   sim_op,
   output logic   fault_v,
   output cause_e fault_c
);
   logic ill_any;

   generate
      if (SIM_OP_TRAPS) begin : g_sim_traps
         assign ill_any = ill_insn | sim_op;
      end else begin : g_sim_nop
         logic unused_sim;
         assign unused_sim = sim_op;
         assign ill_any    = ill_insn;
      end
   endgenerate

   always_comb begin
      fault_v = 1'b1;
      if (bus_err)       fault_c = CAUSE_BUSERR;
      else if (ill_any)  fault_c = CAUSE_ILLOP;
      else if (div_zero) fault_c = CAUSE_DIVZ;
      else begin
         fault_v = 1'b0;
         fault_c = CAUSE_NONE;
      end
   end

   always_comb begin
      if (fault_v) begin
         AST_FAULT_CODE_RANGE: assert (fault_c inside {CAUSE_BUSERR, CAUSE_ILLOP, CAUSE_DIVZ}); // R6
      end
   end

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
   import priv_mode_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   irq_pend,
   input  logic   lock_act,
   input  logic   gie_set,
   input  logic   gie_clr,
   input  logic   wait_req,
   input  logic   halt_req,
   input  logic   brk_req,
   input  logic   fault_v,
   input  cause_e fault_c,
   output logic   user_q,
   output logic   sleep_q,
   output logic   halt_q,
   output cause_e cause_q
);
   logic   irq_eff;
   logic   n_user, n_sleep, n_halt;
   cause_e n_cause;

   assign irq_eff = irq_pend & ~lock_act;

   always_comb begin
      n_user  = user_q;
      n_sleep = sleep_q;
      n_halt  = halt_q;
      n_cause = cause_q;
      if (!halt_q) begin
         if (brk_req) begin
            n_halt = 1'b1;
         end else if (user_q) begin
            if (irq_eff) begin
               n_user  = 1'b0;
               n_sleep = 1'b0;
               n_cause = CAUSE_IRQ;
            end else if (!sleep_q) begin
               if (fault_v) begin
                  n_user  = 1'b0;
                  n_cause = fault_c;
               end else if (gie_clr) begin
                  n_user  = 1'b0;
                  n_cause = CAUSE_TRAP;
               end else if (wait_req || halt_req) begin
                  n_sleep = 1'b1;
               end
            end
         end else begin
            if (halt_req) begin
               n_halt = 1'b1;
            end else if ((wait_req || gie_set) && !irq_eff) begin
               n_user  = 1'b1;
               n_sleep = wait_req;
               n_cause = CAUSE_NONE;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         user_q  <= 1'b0;
         sleep_q <= 1'b0;
         halt_q  <= 1'b0;
         cause_q <= CAUSE_NONE;
      end else begin
         user_q  <= n_user;
         sleep_q <= n_sleep;
         halt_q  <= n_halt;
         cause_q <= n_cause;
      end
   end

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |=> (halt_q && $stable(user_q) && $stable(cause_q))); // R9

   AST_SLEEP_ONLY_USER: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_q |-> user_q); // R8

   AST_ENTRY_CLEARS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(user_q) |-> (cause_q == CAUSE_NONE)); // R2

   AST_PENDING_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (!user_q && gie_set && irq_pend && !lock_act) |=> !user_q); // R3

   AST_LOCK_DEFERS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_act && cause_q != CAUSE_IRQ) |=> (cause_q != CAUSE_IRQ)); // R11

   AST_BREAK_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req && !halt_q) |=> (halt_q && $stable(user_q))); // R10

endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
   import priv_mode_pkg::*;
#(
   parameter int BANK_W       = 1,
   parameter int SUP_BANK     = 0,
   parameter int USR_BANK     = 1,
   parameter int LOCK_INSNS   = 3,
   parameter bit SIM_OP_TRAPS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_pend,
   input  logic              gie_set,
   input  logic              gie_clr,
   input  logic              bus_err,
   input  logic              ill_insn,
   input  logic              div_zero,
   input  logic              wait_req,
   input  logic              halt_req,
   input  logic              brk_req,
   input  logic              lock_req,
   input  logic              sim_op,
   input  logic              insn_retire,
   output logic              user_mode,
   output logic [BANK_W-1:0] bank_sel,
   output logic              sleeping,
   output logic              halted,
   output logic [CAUSE_W-1:0] exc_cause,
   output logic              bus_hold
);
   localparam logic [BANK_W-1:0] SUP_IDX = BANK_W'(SUP_BANK);
   localparam logic [BANK_W-1:0] USR_IDX = BANK_W'(USR_BANK);

   generate
      if (BANK_W < 1) begin : g_bad_w
         $error("priv_mode_ctrl: BANK_W must be at least 1");
      end
      if (SUP_BANK == USR_BANK) begin : g_bad_banks
         $error("priv_mode_ctrl: the two bank indices must differ");
      end
      if (SUP_BANK >= (1 << BANK_W) || USR_BANK >= (1 << BANK_W)) begin : g_bad_range
         $error("priv_mode_ctrl: bank index does not fit BANK_W");
      end
   endgenerate

   logic   lock_act;
   logic   fault_v;
   cause_e fault_c;
   cause_e cause_q;

   lock_window #(.LOCK_INSNS(LOCK_INSNS)) u_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .lock_req    (lock_req),
      .insn_retire (insn_retire),
      .lock_act    (lock_act)
   );

   fault_decode #(.SIM_OP_TRAPS(SIM_OP_TRAPS)) u_fault (
      .bus_err  (bus_err),
      .ill_insn (ill_insn),
      .div_zero (div_zero),
      .sim_op   (sim_op),
      .fault_v  (fault_v),
      .fault_c  (fault_c)
   );

   mode_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_pend (irq_pend),
      .lock_act (lock_act),
      .gie_set  (gie_set),
      .gie_clr  (gie_clr),
      .wait_req (wait_req),
      .halt_req (halt_req),
      .brk_req  (brk_req),
      .fault_v  (fault_v),
      .fault_c  (fault_c),
      .user_q   (user_mode),
      .sleep_q  (sleeping),
      .halt_q   (halted),
      .cause_q  (cause_q)
   );

   assign bank_sel  = user_mode ? USR_IDX : SUP_IDX;
   assign exc_cause = cause_q;
   assign bus_hold  = lock_act;

   AST_SUP_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!user_mode && !$past(user_mode)) |-> $stable(exc_cause)); // R12

   AST_USER_BANK_PICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(user_mode) |-> (bank_sel != $past(bank_sel))); // R2

endmodule

// File: tb/sim_priv_mode_ctrl.sv
module sim_priv_mode_ctrl;
   localparam int P_SET = 0, P_CLR = 1, P_BUS = 2, P_ILL = 3, P_DIV = 4,
                  P_WAIT = 5, P_HALT = 6, P_BRK = 7, P_LOCK = 8, P_SIM = 9, P_RET = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq = 1'b0;
   logic [10:0] pv = '0;
   logic        user_mode, sleeping, halted, bus_hold;
   logic [0:0]  bank_sel;
   logic [2:0]  exc_cause;

   int checks = 0;
   int failures = 0;
   string cur_req = "R1";

   // reference model state
   int m_user, m_sleep, m_halt, m_cause, m_lock;

   always #4 clk = ~clk;

   priv_mode_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .irq_pend(irq),
      .gie_set(pv[P_SET]), .gie_clr(pv[P_CLR]), .bus_err(pv[P_BUS]),
      .ill_insn(pv[P_ILL]), .div_zero(pv[P_DIV]), .wait_req(pv[P_WAIT]),
      .halt_req(pv[P_HALT]), .brk_req(pv[P_BRK]), .lock_req(pv[P_LOCK]),
      .sim_op(pv[P_SIM]), .insn_retire(pv[P_RET]),
      .user_mode(user_mode), .bank_sel(bank_sel), .sleeping(sleeping),
      .halted(halted), .exc_cause(exc_cause), .bus_hold(bus_hold)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_user = 0; m_sleep = 0; m_halt = 0; m_cause = 0; m_lock = 0;
      end else begin
         int ie, flt, fc, nl;
         ie = (irq && m_lock == 0);
         flt = 1; fc = 0;
         if (pv[P_BUS]) fc = 3;
         else if (pv[P_ILL] || pv[P_SIM]) fc = 4;
         else if (pv[P_DIV]) fc = 5;
         else flt = 0;
         if (pv[P_LOCK]) nl = 3;
         else if (pv[P_RET] && m_lock > 0) nl = m_lock - 1;
         else nl = m_lock;
         if (m_halt == 0) begin
            if (pv[P_BRK]) m_halt = 1;
            else if (m_user != 0) begin
               if (ie != 0) begin m_user = 0; m_sleep = 0; m_cause = 1; end
               else if (m_sleep == 0) begin
                  if (flt != 0) begin m_user = 0; m_cause = fc; end
                  else if (pv[P_CLR]) begin m_user = 0; m_cause = 2; end
                  else if (pv[P_WAIT] || pv[P_HALT]) m_sleep = 1;
               end
            end else begin
               if (pv[P_HALT]) m_halt = 1;
               else if ((pv[P_WAIT] || pv[P_SET]) && ie == 0) begin
                  m_user = 1; m_sleep = pv[P_WAIT] ? 1 : 0; m_cause = 0;
               end
            end
         end
         m_lock = nl;
      end
   end

   // per-cycle comparison against the model, away from the edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (user_mode !== m_user[0] || bank_sel !== m_user[0] || sleeping !== m_sleep[0] ||
             halted !== m_halt[0] || exc_cause !== m_cause[2:0] || bus_hold !== (m_lock != 0)) begin
            failures++;
            $display("FAIL %s model: got u=%0b b=%0b s=%0b h=%0b c=%0d l=%0b exp u=%0d s=%0d h=%0d c=%0d l=%0d",
                     cur_req, user_mode, bank_sel, sleeping, halted, exc_cause, bus_hold,
                     m_user, m_sleep, m_halt, m_cause, m_lock != 0);
         end
      end
   end

   task automatic drive(input logic [10:0] p, input logic i);
      @(posedge clk); #2;
      pv = p; irq = i;
   endtask

   task automatic pulse(input int bit_idx, input logic i);
      logic [10:0] p;
      p = '0;
      p[bit_idx] = 1'b1;
      drive(p, i);
      drive('0, i);
   endtask

   task automatic expect_st(input string req, input logic eu, input logic es,
                            input logic eh, input int ec, input logic el);
      checks++;
      if (user_mode !== eu || sleeping !== es || halted !== eh ||
          exc_cause !== ec[2:0] || bus_hold !== el) begin
         failures++;
         $display("FAIL %s: got u=%0b s=%0b h=%0b c=%0d l=%0b exp u=%0b s=%0b h=%0b c=%0d l=%0b",
                  req, user_mode, sleeping, halted, exc_cause, bus_hold, eu, es, eh, ec, el);
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #2;
      rst_n = 1'b0; pv = '0; irq = 1'b0;
      @(posedge clk); #2;
      rst_n = 1'b1;
      @(posedge clk); #2;
   endtask

   initial begin
      #1_600_000;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();
      cur_req = "R1";
      expect_st("R1 reset", 0, 0, 0, 0, 0);
      if (bank_sel !== 1'b0) begin failures++; $display("FAIL R1 bank: got %0b exp 0", bank_sel); end
      checks++;

      cur_req = "R3";
      pulse(P_SET, 1'b1);
      expect_st("R3 set blocked by pending irq", 0, 0, 0, 0, 0);
      pulse(P_WAIT, 1'b1);
      expect_st("R3 wait blocked by pending irq", 0, 0, 0, 0, 0);

      cur_req = "R2";
      pulse(P_SET, 1'b0);
      expect_st("R2 enter user", 1, 0, 0, 0, 0);
      checks++;
      if (bank_sel !== 1'b1) begin failures++; $display("FAIL R2 bank: got %0b exp 1", bank_sel); end

      cur_req = "R4";
      drive('0, 1'b1); drive('0, 1'b0);
      expect_st("R4 irq returns", 0, 0, 0, 1, 0);

      cur_req = "R5";
      pulse(P_SET, 1'b0);
      pulse(P_CLR, 1'b0);
      expect_st("R5 trap", 0, 0, 0, 2, 0);

      cur_req = "R6";
      pulse(P_SET, 1'b0);
      drive(11'b1 << P_BUS | 11'b1 << P_ILL | 11'b1 << P_CLR, 1'b0); drive('0, 1'b0);
      expect_st("R6 bus error wins", 0, 0, 0, 3, 0);
      pulse(P_SET, 1'b0);
      drive(11'b1 << P_ILL | 11'b1 << P_DIV, 1'b0); drive('0, 1'b0);
      expect_st("R6 illegal beats divzero", 0, 0, 0, 4, 0);
      pulse(P_SET, 1'b0);
      pulse(P_DIV, 1'b0);
      expect_st("R6 divzero", 0, 0, 0, 5, 0);

      cur_req = "R12";
      pulse(P_BUS, 1'b0);
      pulse(P_CLR, 1'b0);
      expect_st("R12 supervisor cause sticky", 0, 0, 0, 5, 0);

      cur_req = "R7";
      pulse(P_SET, 1'b0);
      pulse(P_SIM, 1'b0);
      expect_st("R7 sim opcode illegal", 0, 0, 0, 4, 0);

      cur_req = "R8";
      pulse(P_WAIT, 1'b0);
      expect_st("R8 wait from supervisor", 1, 1, 0, 0, 0);
      pulse(P_BUS, 1'b0);
      pulse(P_CLR, 1'b0);
      expect_st("R8 faults ignored asleep", 1, 1, 0, 0, 0);
      drive('0, 1'b1); drive('0, 1'b0);
      expect_st("R8 irq wakes to supervisor", 0, 0, 0, 1, 0);
      pulse(P_SET, 1'b0);
      pulse(P_HALT, 1'b0);
      expect_st("R8 halt in user sleeps", 1, 1, 0, 0, 0);
      drive('0, 1'b1); drive('0, 1'b0);
      expect_st("R8 irq ends user halt", 0, 0, 0, 1, 0);

      cur_req = "R11";
      pulse(P_SET, 1'b0);
      pulse(P_LOCK, 1'b0);
      expect_st("R11 lock opens", 1, 0, 0, 0, 1);
      drive('0, 1'b1); drive('0, 1'b1);
      expect_st("R11 irq deferred", 1, 0, 0, 0, 1);
      drive(11'b1 << P_RET, 1'b1); drive(11'b1 << P_RET, 1'b1);
      drive('0, 1'b1);
      expect_st("R11 still held after two", 1, 0, 0, 0, 1);
      drive(11'b1 << P_RET, 1'b1);
      drive('0, 1'b1);
      expect_st("R11 window closed", 1, 0, 0, 0, 0);
      drive('0, 1'b0);
      expect_st("R11 deferred irq taken", 0, 0, 0, 1, 0);

      cur_req = "R10";
      pulse(P_SET, 1'b0);
      pulse(P_BRK, 1'b0);
      expect_st("R10 break halts in user", 1, 0, 1, 0, 0);

      cur_req = "R9";
      pulse(P_CLR, 1'b0);
      drive('0, 1'b1); drive('0, 1'b0);
      expect_st("R9 halted frozen", 1, 0, 1, 0, 0);
      do_reset();
      pulse(P_HALT, 1'b0);
      expect_st("R9 supervisor halt", 0, 0, 1, 0, 0);
      pulse(P_SET, 1'b0);
      expect_st("R9 halted ignores enable", 0, 0, 1, 0, 0);

      cur_req = "R10";
      do_reset();
      pulse(P_BRK, 1'b0);
      expect_st("R10 break halts in supervisor", 0, 0, 1, 0, 0);

      drive('0, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule